// File: doc/BRIEF.md
# Sixteen-Window Address Decoder with Security Checks

This block turns a transaction address into a target identifier by comparing it against sixteen programmable address windows. Each window has a base page and an inclusive last page at 1 MB granularity, an enable, and a 4-bit target identifier. When an address falls inside an enabled window, the decoder reports a hit, the number of the matching window and that window's target. When no window covers the address, it reports a miss. The decode path is purely combinational, so the result is valid in the cycle in which the address is presented.

Window 0 serves as the configuration window. It is always enabled and always 16 MB long, so software can only move its base and retarget it. Every window also holds four security bits. Two of them guard decoded traffic: a non-secure read, or a non-secure write, into a window that demands secure access is reported as a security error instead of a hit. The other two guard that window's own register slot on the 32-bit programming bus.

Top module: `addr_window_decoder`

## Requirements
- R1: Window n owns register bytes n*0x20 to n*0x20+0x1F. Its words are: control at +0x0, security at +0x4, base at +0x8 and last-page at +0xC. In the control word, bit 0 is the enable and bits [11:8] are the target. Every other bit of these words, and every other word in the slot, reads as zero.
- R2: Window 0 always reads as enabled, and writes to its enable bit have no effect. It covers exactly the 16 MB that start at its base, whatever its last-page word holds. Its target and its base stay writable.
- R3: In the base and last-page words, bits [31:4] hold address bits [47:20], and bits [3:0] read as zero.
- R4: A window n≥1 matches when it is enabled and base ≤ address ≤ {last-page field, 20'hFFFFF}, with both bounds inclusive. A disabled window never matches.
- R5: When several windows match, the lowest-numbered one is selected.
- R6: On a miss, dec_hit and dec_sec_err are 0 and dec_win and dec_target are 0. dec_target is 0 whenever dec_hit is 0.
- R7: Security word bit 3 requires secure reads and bit 2 requires secure writes. A non-secure access of the protected kind to the selected window raises dec_sec_err, drops dec_hit and sets dec_win to that window. The other kind of access, and any secure access, decodes normally.
- R8: Security word bit 0 causes non-secure register writes to any word of that window's slot to be ignored. Bit 1 causes non-secure register reads from that slot to return zero.
- R9: After reset, windows 1 to 15 are disabled, all security bits and all bounds are zero, and window 0 has base 0 and target 0.
- R10: reg_rdata takes the addressed word on the clock edge at which reg_rd_en is sampled high, and holds its value at every other edge.
- R11: The decode outputs follow dec_addr, dec_is_write and dec_secure combinationally, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Register access is secure |
| reg_rdata | output | 32 | Registered read data |
| dec_addr | input | 48 | Transaction address |
| dec_is_write | input | 1 | Transaction is a write |
| dec_secure | input | 1 | Transaction is secure |
| dec_hit | output | 1 | Address decoded to a target |
| dec_sec_err | output | 1 | Security violation on the selected window |
| dec_win | output | 4 | Selected window number |
| dec_target | output | 4 | Target of the selected window |

## Verification
The bench builds the block with its default parameters: sixteen windows, a 48-bit address, a 4-bit target and a 16 MB configuration window. At this size the full register map is addressable, including the highest slot and the top of the address space. Because the window stride is 1 MB, the bench can place bounds just one page apart, which makes it possible to probe the first and last byte of each window, the overlap between windows and the exact edge of the fixed configuration window once its base has been moved.

// File: rtl/awd_pkg.sv
package awd_pkg;
   // word index inside a window's register slot
   localparam int unsigned WORD_CTRL = 0;
   localparam int unsigned WORD_SEC  = 1;
   localparam int unsigned WORD_BASE = 2;
   localparam int unsigned WORD_LAST = 3;
   // bit positions inside the words
   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned CTRL_TID_LSB = 8;
   localparam int unsigned PAGE_LSB     = 4;
   localparam int unsigned SEC_W        = 4;
   localparam int unsigned SEC_REGWR    = 0;
   localparam int unsigned SEC_REGRD    = 1;
   localparam int unsigned SEC_WR       = 2;
   localparam int unsigned SEC_RD       = 3;
   localparam int unsigned SLOT_BYTES_LOG2 = 5;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN = 16,
   parameter int unsigned TID_W   = 4,
   parameter int unsigned PAGE_W  = 28,
   parameter int unsigned REG_AW  = 9
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic                             rd_en,
   input  logic [REG_AW-1:0]                addr,
   input  logic [31:0]                      wdata,
   input  logic                             secure,
   output logic [31:0]                      rdata,
   output logic [NUM_WIN-1:0]               win_en,
   output logic [NUM_WIN-1:0][TID_W-1:0]    win_tid,
   output logic [NUM_WIN-1:0][PAGE_W-1:0]   win_base,
   output logic [NUM_WIN-1:0][PAGE_W-1:0]   win_last,
   output logic [NUM_WIN-1:0][SEC_W-1:0]    win_sec
);
   localparam int unsigned SLOT_W = REG_AW - SLOT_BYTES_LOG2;

   logic [SLOT_W-1:0] slot;
   logic [2:0]        word;
   assign slot = addr[REG_AW-1:SLOT_BYTES_LOG2];
   assign word = addr[SLOT_BYTES_LOG2-1:2];

   logic [NUM_WIN-1:0][31:0] rd_ctrl, rd_sec, rd_base, rd_last;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic sel_wr;
      assign sel_wr = wr_en && (slot == SLOT_W'(i)) &&
                      (secure || !win_sec[i][SEC_REGWR]);

      if (i == 0) begin : g_cfg
         assign win_en[i] = 1'b1;
      end else begin : g_gen
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               win_en[i] <= 1'b0;
            else if (sel_wr && word == 3'(WORD_CTRL))
               win_en[i] <= wdata[CTRL_EN_BIT];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_tid[i]  <= '0;
            win_sec[i]  <= '0;
            win_base[i] <= '0;
            win_last[i] <= '0;
         end else if (sel_wr) begin
            case (word)
               3'(WORD_CTRL): win_tid[i]  <= wdata[CTRL_TID_LSB +: TID_W];
               3'(WORD_SEC):  win_sec[i]  <= wdata[SEC_W-1:0];
               3'(WORD_BASE): win_base[i] <= wdata[PAGE_LSB +: PAGE_W];
               3'(WORD_LAST): win_last[i] <= wdata[PAGE_LSB +: PAGE_W];
               default: ;
            endcase
         end
      end

      always_comb begin
         rd_ctrl[i] = '0;
         rd_ctrl[i][CTRL_EN_BIT] = win_en[i];
         rd_ctrl[i][CTRL_TID_LSB +: TID_W] = win_tid[i];
         rd_sec[i]  = 32'(win_sec[i]);
         rd_base[i] = '0;
         rd_base[i][PAGE_LSB +: PAGE_W] = win_base[i];
         rd_last[i] = '0;
         rd_last[i][PAGE_LSB +: PAGE_W] = win_last[i];
      end
   end

   logic [31:0] rd_word;
   always_comb begin
      rd_word = '0;
      if (32'(slot) < NUM_WIN) begin
         if (secure || !win_sec[slot][SEC_REGRD]) begin
            case (word)
               3'(WORD_CTRL): rd_word = rd_ctrl[slot];
               3'(WORD_SEC):  rd_word = rd_sec[slot];
               3'(WORD_BASE): rd_word = rd_base[slot];
               3'(WORD_LAST): rd_word = rd_last[slot];
               default:       rd_word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
   parameter int unsigned PAGE_W     = 28,
   parameter bit          FIXED_SIZE = 1'b0,
   parameter int unsigned FIX_PAGES  = 16
) (
   input  logic              en,
   input  logic [PAGE_W-1:0] addr_pg,
   input  logic [PAGE_W-1:0] base_pg,
   input  logic [PAGE_W-1:0] last_pg,
   output logic              hit
);
   logic above_base;
   assign above_base = (addr_pg >= base_pg);

   if (FIXED_SIZE) begin : g_fixed
      logic [PAGE_W-1:0] offset_pg;
      logic              unused_last;
      assign offset_pg   = addr_pg - base_pg;
      assign unused_last = ^last_pg;
      assign hit = en && above_base && (offset_pg < PAGE_W'(FIX_PAGES));
   end else begin : g_range
      assign hit = en && above_base && (addr_pg <= last_pg);
   end
endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
   parameter int unsigned N     = 16,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN      = 16,
   parameter int unsigned ADDR_W       = 48,
   parameter int unsigned TID_W        = 4,
   parameter int unsigned GRAN_LOG2    = 20,
   parameter int unsigned CFG_SIZE_LOG2 = 24,
   parameter int unsigned WIN_W        = $clog2(NUM_WIN),
   parameter int unsigned REG_AW       = WIN_W + SLOT_BYTES_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_secure,
   output logic [31:0]       reg_rdata,
   input  logic [ADDR_W-1:0] dec_addr,
   input  logic              dec_is_write,
   input  logic              dec_secure,
   output logic              dec_hit,
   output logic              dec_sec_err,
   output logic [WIN_W-1:0]  dec_win,
   output logic [TID_W-1:0]  dec_target
);
   localparam int unsigned PAGE_W    = ADDR_W - GRAN_LOG2;
   localparam int unsigned CFG_PAGES = 1 << (CFG_SIZE_LOG2 - GRAN_LOG2);

   if (NUM_WIN < 2 || (1 << WIN_W) != NUM_WIN) begin : g_bad_num
      $error("NUM_WIN must be a power of two, at least 2");
   end
   if (PAGE_LSB + PAGE_W > 32) begin : g_bad_page
      $error("page field does not fit a 32-bit word");
   end
   if (CTRL_TID_LSB + TID_W > 32) begin : g_bad_tid
      $error("target field does not fit the control word");
   end
   if (CFG_SIZE_LOG2 < GRAN_LOG2) begin : g_bad_cfg
      $error("configuration window smaller than one page");
   end

   logic [NUM_WIN-1:0]              win_en;
   logic [NUM_WIN-1:0][TID_W-1:0]   win_tid;
   logic [NUM_WIN-1:0][PAGE_W-1:0]  win_base;
   logic [NUM_WIN-1:0][PAGE_W-1:0]  win_last;
   logic [NUM_WIN-1:0][SEC_W-1:0]   win_sec;

   awd_regfile #(
      .NUM_WIN(NUM_WIN), .TID_W(TID_W), .PAGE_W(PAGE_W), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
      .wdata(reg_wdata), .secure(reg_secure), .rdata(reg_rdata),
      .win_en(win_en), .win_tid(win_tid), .win_base(win_base),
      .win_last(win_last), .win_sec(win_sec)
   );

   logic [PAGE_W-1:0]  addr_pg;
   logic [NUM_WIN-1:0] win_hit;
   assign addr_pg = dec_addr[ADDR_W-1 -: PAGE_W];

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
      awd_win_match #(
         .PAGE_W(PAGE_W), .FIXED_SIZE(i == 0), .FIX_PAGES(CFG_PAGES)
      ) u_match (
         .en(win_en[i]), .addr_pg(addr_pg), .base_pg(win_base[i]),
         .last_pg(win_last[i]), .hit(win_hit[i])
      );
   end

   logic             any_hit;
   logic [WIN_W-1:0] sel;

   awd_prio_pick #(.N(NUM_WIN), .IDX_W(WIN_W)) u_pick (
      .req(win_hit), .any(any_hit), .idx(sel)
   );

   logic need_sec, violation;
   assign need_sec  = dec_is_write ? win_sec[sel][SEC_WR] : win_sec[sel][SEC_RD];
   assign violation = any_hit && need_sec && !dec_secure;

   assign dec_hit     = any_hit && !violation;
   assign dec_sec_err = violation;
   assign dec_win     = any_hit ? sel : '0;
   assign dec_target  = dec_hit ? win_tid[sel] : '0;
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int unsigned ADDR_W    = 48,
   parameter int unsigned PAGE_W    = 28,
   parameter int unsigned WIN_W     = 4,
   parameter int unsigned CFG_PAGES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd_en,
   input logic [31:0]       reg_rdata,
   input logic [ADDR_W-1:0] dec_addr,
   input logic              dec_secure,
   input logic              dec_hit,
   input logic              dec_sec_err,
   input logic [WIN_W-1:0]  dec_win,
   input logic [PAGE_W-1:0] cfg_base_pg
);
   logic [PAGE_W-1:0] a_pg, a_off;
   logic              in_cfg;
   assign a_pg   = dec_addr[ADDR_W-1 -: PAGE_W];
   assign a_off  = a_pg - cfg_base_pg;
   assign in_cfg = (a_pg >= cfg_base_pg) && (a_off < PAGE_W'(CFG_PAGES));

   // R2 and R5: the configuration window is never disabled and has top priority
   a_r2_cfg_window_wins: assert property (@(posedge clk) disable iff (!rst_n)
      in_cfg |-> ((dec_hit || dec_sec_err) && dec_win == '0));

   // R7: a hit and a security error never occur together
   a_r7_hit_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_hit && dec_sec_err));

   // R7: only non-secure traffic can violate
   a_r7_err_needs_nonsecure: assert property (@(posedge clk) disable iff (!rst_n)
      dec_sec_err |-> !dec_secure);

   // R10: read data is held when no read was sampled
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_en |=> $stable(reg_rdata));

   // R6: on a miss the window number is zero
   a_r6_miss_win_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_hit && !dec_sec_err) |-> dec_win == '0);
endmodule

bind addr_window_decoder awd_checker #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .CFG_PAGES(CFG_PAGES)
) u_awd_checker (
   .clk(clk), .rst_n(rst_n), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
   .dec_addr(dec_addr), .dec_secure(dec_secure), .dec_hit(dec_hit),
   .dec_sec_err(dec_sec_err), .dec_win(dec_win), .cfg_base_pg(win_base[0])
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0, reg_secure = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [47:0] dec_addr = '0;
   logic        dec_is_write = 1'b0, dec_secure = 1'b0;
   logic        dec_hit, dec_sec_err;
   logic [3:0]  dec_win, dec_target;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   addr_window_decoder dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_secure(reg_secure),
      .reg_rdata(reg_rdata), .dec_addr(dec_addr), .dec_is_write(dec_is_write),
      .dec_secure(dec_secure), .dec_hit(dec_hit), .dec_sec_err(dec_sec_err),
      .dec_win(dec_win), .dec_target(dec_target)
   );

   // {addr, is_write, secure, hit, sec_err, win, target}
   localparam int NV = 14;
   localparam logic [59:0] VEC [NV] = '{
      {48'h0000_0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0},
      {48'h0000_00FF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0},
      {48'h0000_0100_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd2},
      {48'h0000_01FF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd2},
      {48'h0000_0200_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 4'd3},
      {48'h0000_02FF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 4'd3},
      {48'h0000_0300_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
      {48'h0000_1000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 4'd0},
      {48'h0000_100F_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 4'd5},
      {48'h0000_1000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 4'd5},
      {48'h0000_2000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 4'd0},
      {48'h0000_2FFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 4'd7},
      {48'h0000_3000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
      {48'hFFFF_FFF0_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0}
   };

   function automatic logic [8:0] ra(input int win, input int word);
      return 9'(win * 32 + word * 4);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int win, input int word, input logic [31:0] d, input logic sec);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = ra(win, word); reg_wdata = d; reg_secure = sec;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_secure = 1'b0;
   endtask

   task automatic rd(input int win, input int word, input logic sec, output logic [31:0] d);
      @(negedge clk);
      reg_rd_en = 1'b1; reg_addr = ra(win, word); reg_secure = sec;
      @(negedge clk);
      reg_rd_en = 1'b0; reg_secure = 1'b0;
      d = reg_rdata;
   endtask

   task automatic dec(input logic [47:0] a, input logic w, input logic s);
      @(negedge clk);
      dec_addr = a; dec_is_write = w; dec_secure = s;
      #1;
   endtask

   task automatic dec_expect(input string req, input logic [47:0] a, input logic w,
                             input logic s, input logic h, input logic e,
                             input logic [3:0] wn, input logic [3:0] t);
      dec(a, w, s);
      check(req, {dec_hit, dec_sec_err, dec_win, dec_target}, {h, e, wn, t});
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 / R1 / R2: reset state
      rd(0, 0, 1'b0, d); check("R9 win0 ctrl after reset", d, 32'h1);
      rd(1, 0, 1'b0, d); check("R9 win1 ctrl after reset", d, 32'h0);
      rd(15, 1, 1'b0, d); check("R9 win15 security after reset", d, 32'h0);
      dec_expect("R9 reset decode miss", 48'h0000_0100_0000, 0, 0, 0, 0, 0, 0);

      // R1 / R3: readback masking
      wr(1, 2, 32'hFFFF_FFFF, 1'b1);
      rd(1, 2, 1'b0, d); check("R3 base low bits read zero", d, 32'hFFFF_FFF0);
      wr(7, 0, 32'hFFFF_FFFF, 1'b0);
      rd(7, 0, 1'b0, d); check("R1 control unused bits zero", d, 32'h0000_0F01);
      wr(7, 0, 32'h0, 1'b0);
      rd(7, 5, 1'b0, d); check("R1 unused slot word reads zero", d, 32'h0);

      // program windows
      wr(1, 2, 32'h0000_0100, 1'b0); wr(1, 3, 32'h0000_01F0, 1'b0); wr(1, 0, 32'h0201, 1'b0);
      wr(2, 2, 32'h0000_0180, 1'b0); wr(2, 3, 32'h0000_02F0, 1'b0); wr(2, 0, 32'h0301, 1'b0);
      wr(3, 2, 32'h0000_1000, 1'b0); wr(3, 3, 32'h0000_1000, 1'b0); wr(3, 0, 32'h0501, 1'b0);
      wr(3, 1, 32'h8, 1'b0);
      wr(4, 2, 32'h0000_2000, 1'b0); wr(4, 3, 32'h0000_2FF0, 1'b0); wr(4, 0, 32'h0701, 1'b0);
      wr(4, 1, 32'h4, 1'b0);
      wr(5, 2, 32'h0000_3000, 1'b0); wr(5, 3, 32'h0000_30F0, 1'b0); wr(5, 0, 32'h0600, 1'b0);

      // table walk: R4 R5 R6 R7 R11 R2
      for (int i = 0; i < NV; i++) begin
         dec(VEC[i][59:12], VEC[i][11], VEC[i][10]);
         check($sformatf("R4/R5/R6/R7/R11 vector %0d", i),
               {dec_hit, dec_sec_err, dec_win, dec_target}, VEC[i][9:0]);
      end

      // R11: combinational response in the same cycle
      dec(48'h0000_0100_0000, 0, 0);
      dec_addr = 48'h0000_0200_0000; #0.5;
      check("R11 same-cycle decode", {dec_win, dec_target}, {4'd2, 4'd3});

      // R2: window 0 enable cannot be cleared, target writable, base movable
      wr(0, 0, 32'h0000_0400, 1'b0);
      rd(0, 0, 1'b0, d); check("R2 win0 enable stuck on", d, 32'h0000_0401);
      dec_expect("R2 win0 retargeted", 48'h0000_0000_0000, 0, 0, 1, 0, 0, 4);
      wr(0, 3, 32'h0000_0000, 1'b0);
      wr(0, 2, 32'h0000_4000, 1'b0);
      dec_expect("R2 win0 moved, first byte", 48'h0000_4000_0000, 0, 0, 1, 0, 0, 4);
      dec_expect("R2 win0 moved, last byte", 48'h0000_40FF_FFFF, 0, 0, 1, 0, 0, 4);
      dec_expect("R2 win0 moved, one past end", 48'h0000_4100_0000, 0, 0, 0, 0, 0, 0);
      dec_expect("R2 old base no longer decodes", 48'h0000_0000_0000, 0, 0, 0, 0, 0, 0);
      // R5: win0 overlapping win1 takes priority
      wr(0, 2, 32'h0000_0180, 1'b0);
      dec_expect("R5 win0 beats win1", 48'h0000_01F0_0000, 0, 0, 1, 0, 0, 4);

      // R4: disable a window
      wr(2, 0, 32'h0300, 1'b0);
      dec_expect("R4 disabled window misses", 48'h0000_0280_0000, 0, 0, 0, 0, 0, 0);

      // R8: register-slot protection
      wr(6, 0, 32'h0101, 1'b1);
      wr(6, 1, 32'h3, 1'b1);
      wr(6, 0, 32'h0F00, 1'b0);
      rd(6, 0, 1'b1, d); check("R8 non-secure write ignored", d, 32'h0000_0101);
      wr(6, 1, 32'h0, 1'b0);
      rd(6, 1, 1'b1, d); check("R8 security word kept", d, 32'h3);
      rd(6, 0, 1'b0, d); check("R8 non-secure read returns zero", d, 32'h0);

      // R10: read data held across non-read cycles
      rd(1, 0, 1'b0, d);
      wr(1, 0, 32'h0901, 1'b0);
      repeat (2) @(negedge clk);
      check("R10 rdata held", reg_rdata, 32'h0000_0201);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule